// File: doc/BRIEF.md
# Receive Queue Halt and Event Status Register

This block is the status word for an eight-queue receive engine. Each queue has two sticky flags: one records that a frame event occurred on the queue, the other records that hardware halted the queue. A queue is halted when it runs out of receive descriptors or when a receive error stops a frame aimed at it. Software reads the whole 32-bit word and clears a flag by writing one to it. Clearing a halted flag is also what lets the queue receive again.

While a queue's halted flag is set, the block asserts that queue's discard output. The receive path then drops the frame in progress and every later frame aimed at that queue. A software request for a graceful stop has no effect on any flag, because only hardware starvation or error events halt a queue. A single interrupt output is high while any flag in the word is set.

Bit 31 is the most significant bit of the register word. In the requirements below, "queue q" runs from 0 to 7.

Top module: `rxq_status_reg`

## Requirements
- R1: After reset, reg_rdata is 0, irq is 0 and q_discard is 0.
- R2: A one-cycle pulse on frame_evt[q] sets the event flag of queue q, which reads at reg_rdata bit (7-q) from the cycle after the pulse.
- R3: A pulse on starve_evt[q] sets the halted flag of queue q, which reads at reg_rdata bit (23-q) from the cycle after the pulse.
- R4: A pulse on err_evt[q] sets the halted flag of queue q at reg_rdata bit (23-q) from the cycle after the pulse.
- R5: graceful_stop has no effect: while it is high and no event or write occurs, reg_rdata keeps its value and no halted flag is set.
- R6: A write (reg_wr high) with a one in the bit position of a flag clears that flag from the next cycle. Flags whose write bit is zero are left unchanged.
- R7: Reserved bits (all bits outside 23..16 and 7..0) always read as zero, including after a write of all ones.
- R8: When a set event and a clearing write hit the same flag in the same cycle, the flag is set in the next cycle.
- R9: q_discard[q] is high from the cycle after queue q's halt event until the cycle after the write that clears its halted flag, and low otherwise.
- R10: irq is high in exactly those cycles in which at least one flag reads as set.
- R11: A set flag stays set over any number of idle cycles until it is cleared by a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_evt | input | 8 | Per-queue frame event pulse |
| starve_evt | input | 8 | Per-queue descriptors-exhausted pulse |
| err_evt | input | 8 | Per-queue receive error pulse |
| graceful_stop | input | 1 | Software graceful-stop request (does not halt queues) |
| reg_wdata | input | 32 | Register write data, ones clear flags |
| reg_wr | input | 1 | Register write strobe |
| reg_rdata | output | 32 | Register read data |
| q_discard | output | 8 | Per-queue discard indication |
| irq | output | 1 | Combined interrupt, high while any flag is set |

## Verification
Every flag change, whether a set event or a clearing write, is due exactly one clock edge after the stimulus. reg_rdata, q_discard and irq all change together in that cycle. The bench drives its stimulus on a falling edge and holds it across one rising edge. It removes the stimulus and samples the outputs on the next falling edge, so every check lands in the first cycle in which the result is due. For the discard window it also samples on the falling edge where the clearing write is driven, to confirm that discard is still high in that cycle, and then one cycle later to confirm it has dropped.

// File: rtl/rxq_status_pkg.sv
package rxq_status_pkg;

   // Register fields are numbered from the most significant bit (index 0).
   // This converts such an index into an LSB-based vector index.
   function automatic int msb_idx(input int pos, input int width);
      return width - 1 - pos;
   endfunction

   // Mask of every defined bit for a given layout.
   function automatic logic [63:0] field_mask(input int nq, input int width,
                                              input int hbase, input int ebase);
      logic [63:0] m;
      m = '0;
      for (int q = 0; q < nq; q++) begin
         m[width - 1 - hbase - q] = 1'b1;
         m[width - 1 - ebase - q] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/rxq_w1c_bank.sv
module rxq_w1c_bank #(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] flags_o,
   output logic [N-1:0] flags_nxt_o
);

   logic [N-1:0] flags_q;

   // Set has priority over a simultaneous clear.
   assign flags_nxt_o = (flags_q & ~clr_i) | set_i;

   always_ff @(posedge clk) begin
      if (!rst_n) flags_q <= '0;
      else        flags_q <= flags_nxt_o;
   end

   assign flags_o = flags_q;

endmodule

// File: rtl/rxq_reg_map.sv
module rxq_reg_map
   import rxq_status_pkg::*;
#(
   parameter int NUM_Q     = 8,
   parameter int REG_W     = 32,
   parameter int HALT_BASE = 8,
   parameter int EVT_BASE  = 24
) (
   input  logic [NUM_Q-1:0] halt_i,
   input  logic [NUM_Q-1:0] evt_i,
   input  logic [REG_W-1:0] wdata_i,
   input  logic             wr_i,
   output logic [REG_W-1:0] rdata_o,
   output logic [NUM_Q-1:0] halt_clr_o,
   output logic [NUM_Q-1:0] evt_clr_o
);

   localparam logic [63:0]      MASK64   = field_mask(NUM_Q, REG_W, HALT_BASE, EVT_BASE);
   localparam logic [REG_W-1:0] DEF_MASK = MASK64[REG_W-1:0];

   logic [REG_W-1:0] unused_wbits;
   assign unused_wbits = wdata_i & ~DEF_MASK;

   for (genvar q = 0; q < NUM_Q; q++) begin : g_q
      localparam int HP = msb_idx(HALT_BASE + q, REG_W);
      localparam int EP = msb_idx(EVT_BASE + q, REG_W);
      assign halt_clr_o[q] = wr_i & wdata_i[HP];
      assign evt_clr_o[q]  = wr_i & wdata_i[EP];
   end

   always_comb begin
      rdata_o = '0;
      for (int q = 0; q < NUM_Q; q++) begin
         rdata_o[msb_idx(HALT_BASE + q, REG_W)] = halt_i[q];
         rdata_o[msb_idx(EVT_BASE + q, REG_W)]  = evt_i[q];
      end
   end

endmodule

// File: rtl/rxq_status_reg.sv
module rxq_status_reg #(
   parameter int NUM_Q     = 8,
   parameter int REG_W     = 32,
   parameter int HALT_BASE = 8,
   parameter int EVT_BASE  = 24,
   parameter bit REG_IRQ   = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NUM_Q-1:0] frame_evt,
   input  logic [NUM_Q-1:0] starve_evt,
   input  logic [NUM_Q-1:0] err_evt,
   input  logic             graceful_stop,
   input  logic [REG_W-1:0] reg_wdata,
   input  logic             reg_wr,
   output logic [REG_W-1:0] reg_rdata,
   output logic [NUM_Q-1:0] q_discard,
   output logic             irq
);

   localparam int NFLAG = 2 * NUM_Q;

   if (NUM_Q < 1 || NUM_Q > REG_W / 2) begin : g_bad_nq
      $error("rxq_status_reg: NUM_Q out of range");
   end
   if (HALT_BASE < 0 || HALT_BASE + NUM_Q > REG_W ||
       EVT_BASE < 0 || EVT_BASE + NUM_Q > REG_W) begin : g_bad_base
      $error("rxq_status_reg: field does not fit the register");
   end
   if (!(HALT_BASE + NUM_Q <= EVT_BASE || EVT_BASE + NUM_Q <= HALT_BASE)) begin : g_bad_ovl
      $error("rxq_status_reg: halt and event fields overlap");
   end

   // A graceful stop never reaches the halt flags.
   logic unused_stop;
   assign unused_stop = graceful_stop;

   logic [NUM_Q-1:0] halt_q, evt_q, halt_clr, evt_clr;
   logic [NFLAG-1:0] flags, flags_nxt;

   rxq_reg_map #(
      .NUM_Q(NUM_Q), .REG_W(REG_W), .HALT_BASE(HALT_BASE), .EVT_BASE(EVT_BASE)
   ) u_map (
      .halt_i     (halt_q),
      .evt_i      (evt_q),
      .wdata_i    (reg_wdata),
      .wr_i       (reg_wr),
      .rdata_o    (reg_rdata),
      .halt_clr_o (halt_clr),
      .evt_clr_o  (evt_clr)
   );

   rxq_w1c_bank #(.N(NFLAG)) u_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .set_i       ({starve_evt | err_evt, frame_evt}),
      .clr_i       ({halt_clr, evt_clr}),
      .flags_o     (flags),
      .flags_nxt_o (flags_nxt)
   );

   assign evt_q     = flags[NUM_Q-1:0];
   assign halt_q    = flags[NFLAG-1:NUM_Q];
   assign q_discard = halt_q;

   if (REG_IRQ) begin : g_irq_reg
      // Flop fed from next state, so timing matches the flags.
      logic irq_q;
      always_ff @(posedge clk) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= |flags_nxt;
      end
      assign irq = irq_q;
   end else begin : g_irq_comb
      logic [NFLAG-1:0] unused_nxt;
      assign unused_nxt = flags_nxt;
      assign irq = |flags;
   end

endmodule

// File: rtl/rxq_status_chk.sv
module rxq_status_chk #(
   parameter int NUM_Q     = 8,
   parameter int REG_W     = 32,
   parameter int HALT_BASE = 8,
   parameter int EVT_BASE  = 24
) (
   input logic             clk,
   input logic             rst_n,
   input logic [NUM_Q-1:0] frame_evt,
   input logic [NUM_Q-1:0] starve_evt,
   input logic [NUM_Q-1:0] err_evt,
   input logic             graceful_stop,
   input logic [REG_W-1:0] reg_wdata,
   input logic             reg_wr,
   input logic [REG_W-1:0] reg_rdata,
   input logic [NUM_Q-1:0] q_discard,
   input logic             irq
);

   logic [REG_W-1:0] def_mask;
   always_comb begin
      def_mask = '0;
      for (int q = 0; q < NUM_Q; q++) begin
         def_mask[REG_W-1-HALT_BASE-q] = 1'b1;
         def_mask[REG_W-1-EVT_BASE-q]  = 1'b1;
      end
   end

   p_reserved_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata & ~def_mask) == '0);

   p_irq_any_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq == (reg_rdata != '0));

   p_stop_inert_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (graceful_stop && !reg_wr && frame_evt == '0 && starve_evt == '0 && err_evt == '0)
      |=> $stable(reg_rdata));

   for (genvar q = 0; q < NUM_Q; q++) begin : g_q
      localparam int HP = REG_W - 1 - HALT_BASE - q;
      localparam int EP = REG_W - 1 - EVT_BASE - q;

      p_evt_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
         frame_evt[q] |=> reg_rdata[EP]);

      // covers R3, R4 and set priority R8
      p_halt_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (starve_evt[q] || err_evt[q]) |=> reg_rdata[HP]);

      p_halt_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (reg_wr && reg_wdata[HP] && !starve_evt[q] && !err_evt[q]) |=> !reg_rdata[HP]);

      p_halt_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
         (reg_rdata[HP] && !(reg_wr && reg_wdata[HP])) |=> reg_rdata[HP]);

      p_evt_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
         (reg_rdata[EP] && !(reg_wr && reg_wdata[EP])) |=> reg_rdata[EP]);

      p_discard_r9: assert property (@(posedge clk) disable iff (!rst_n)
         q_discard[q] == reg_rdata[HP]);
   end

endmodule

bind rxq_status_reg rxq_status_chk #(
   .NUM_Q(NUM_Q), .REG_W(REG_W), .HALT_BASE(HALT_BASE), .EVT_BASE(EVT_BASE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .frame_evt(frame_evt), .starve_evt(starve_evt),
   .err_evt(err_evt), .graceful_stop(graceful_stop), .reg_wdata(reg_wdata),
   .reg_wr(reg_wr), .reg_rdata(reg_rdata), .q_discard(q_discard), .irq(irq)
);

// File: tb/rxq_status_reg_tb.sv
module rxq_status_reg_tb;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [7:0]  frame_evt, starve_evt, err_evt;
   logic        graceful_stop;
   logic [31:0] reg_wdata;
   logic        reg_wr;
   logic [31:0] reg_rdata;
   logic [7:0]  q_discard;
   logic        irq;

   int total = 0;
   int bad   = 0;

   logic [7:0] m_halt, m_evt;

   always #(CLK_PERIOD/2) clk = ~clk;

   rxq_status_reg u_dut (
      .clk(clk), .rst_n(rst_n), .frame_evt(frame_evt), .starve_evt(starve_evt),
      .err_evt(err_evt), .graceful_stop(graceful_stop), .reg_wdata(reg_wdata),
      .reg_wr(reg_wr), .reg_rdata(reg_rdata), .q_discard(q_discard), .irq(irq)
   );

   // Layout from the requirements: halted q at bit 23-q, event q at bit 7-q.
   function automatic logic [31:0] pack(input logic [7:0] h, input logic [7:0] e);
      logic [31:0] r = '0;
      for (int q = 0; q < 8; q++) begin
         r[23-q] = h[q];
         r[7-q]  = e[q];
      end
      return r;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_all(input string req);
      check({req, " rdata"},   reg_rdata, pack(m_halt, m_evt));
      check({req, " discard"}, {24'd0, q_discard}, {24'd0, m_halt});
      check({req, " irq"},     {31'd0, irq}, {31'd0, (m_halt != 0) || (m_evt != 0)});
   endtask

   task automatic idle_inputs();
      frame_evt = '0; starve_evt = '0; err_evt = '0;
      graceful_stop = 1'b0; reg_wdata = '0; reg_wr = 1'b0;
   endtask

   // Stimulus is driven at a falling edge; one rising edge later it is
   // removed and the outputs are sampled at the next falling edge.
   task automatic cycle();
      @(negedge clk);
      idle_inputs();
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      idle_inputs();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      m_halt = '0; m_evt = '0;
      check_all("R1");
   endtask

   task automatic t_frame_events();
      frame_evt = 8'h01; cycle(); m_evt = 8'h01; check_all("R2 q0");
      frame_evt = 8'h80; cycle(); m_evt = 8'h81; check_all("R2 q7");
      frame_evt = 8'h24; cycle(); m_evt = 8'hA5; check_all("R2 multi");
      repeat (5) cycle();
      check_all("R11 sticky evt");
      check("R10 irq", {31'd0, irq}, 32'd1);
   endtask

   task automatic t_clear();
      reg_wr = 1'b1; reg_wdata = 32'h0; cycle();
      check_all("R6 zero write");
      reg_wr = 1'b1; reg_wdata = 32'h0000_0080; cycle(); m_evt = 8'hA4;
      check_all("R6 clear q0 evt");
      reg_wdata = 32'h0000_00FF; cycle();
      check_all("R6 data without strobe");
      reg_wr = 1'b1; reg_wdata = 32'h0000_00FF; cycle(); m_evt = 8'h00;
      check_all("R6 clear all evt");
      check("R10 irq low", {31'd0, irq}, 32'd0);
   endtask

   task automatic t_starve();
      starve_evt = 8'h04; cycle(); m_halt = 8'h04;
      check_all("R3 starve q2");
      check("R9 discard on", {24'd0, q_discard}, 32'h04);
      repeat (4) cycle();
      check_all("R11 sticky halt");
      reg_wr = 1'b1; reg_wdata = 32'h0020_0000;
      check("R9 discard during write", {24'd0, q_discard}, 32'h04);
      cycle(); m_halt = 8'h00;
      check("R9 discard off", {24'd0, q_discard}, 32'h00);
      check_all("R6 halt clear");
   endtask

   task automatic t_error();
      err_evt = 8'hA0; cycle(); m_halt = 8'hA0;
      check_all("R4 err q5 q7");
      check("R10 irq halt", {31'd0, irq}, 32'd1);
      reg_wr = 1'b1; reg_wdata = 32'h0001_0000; cycle(); m_halt = 8'h20;
      check_all("R6 clear q7 halt");
      reg_wr = 1'b1; reg_wdata = 32'h0004_0000; cycle(); m_halt = 8'h00;
      check_all("R6 clear q5 halt");
   endtask

   task automatic t_graceful();
      graceful_stop = 1'b1; cycle();
      check_all("R5 stop from idle");
      frame_evt = 8'h10; cycle(); m_evt = 8'h10;
      for (int i = 0; i < 4; i++) begin
         graceful_stop = 1'b1; cycle();
      end
      check_all("R5 stop holds");
      check("R5 no halt", {24'd0, q_discard}, 32'h0);
   endtask

   task automatic t_reserved();
      reg_wr = 1'b1; reg_wdata = 32'hFFFF_FFFF; cycle(); m_halt = '0; m_evt = '0;
      check_all("R7 all-ones write");
      starve_evt = 8'hFF; frame_evt = 8'hFF; cycle(); m_halt = 8'hFF; m_evt = 8'hFF;
      check("R7 reserved zero", reg_rdata & 32'hFF00_FF00, 32'h0);
      check_all("R7 all set");
      reg_wr = 1'b1; reg_wdata = 32'hFF00_FF00; cycle();
      check_all("R7 reserved write ignored");
      reg_wr = 1'b1; reg_wdata = 32'hFFFF_FFFF; cycle(); m_halt = '0; m_evt = '0;
      check_all("R7 cleared");
   endtask

   task automatic t_collision();
      starve_evt = 8'h02; cycle(); m_halt = 8'h02;
      frame_evt = 8'h40; cycle(); m_evt = 8'h40;
      err_evt = 8'h02; frame_evt = 8'h40; reg_wr = 1'b1; reg_wdata = 32'h0040_0002;
      cycle();
      check_all("R8 set wins");
      starve_evt = 8'h08; reg_wr = 1'b1; reg_wdata = 32'h0010_0000;
      cycle(); m_halt = 8'h0A;
      check_all("R8 set on clear of clear bit");
      reg_wr = 1'b1; reg_wdata = 32'h00FF_00FF; cycle(); m_halt = '0; m_evt = '0;
      check_all("R8 cleared after");
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      t_reset();
      t_frame_events();
      t_clear();
      t_starve();
      t_error();
      t_graceful();
      t_reserved();
      t_collision();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule